// File: doc/BRIEF.md
# Multicart Game-Select Unlock Controller

This block sits on the cartridge side of a CPU bus. It watches write cycles and moves a multi-game cartridge out of its boot-menu state into one of two fixed game personalities. Selection takes two steps in order. First, a key value written to an arm address arms the cartridge and swaps in a second set of program pages. Then a selector value written to a select address, only while armed, commits the game. The chosen personality drives the four 8K program page numbers and the 8K pattern page number, and stays in force until reset.

In personality 2 the block also acts as a simple bank latch. Every write in the upper half of the address space sets the low 16K program bank, the 8K pattern page and the nametable mirroring from the data byte. In personality 1 the page outputs stay frozen, and a separate register-level banking block takes over, enabled from the exported personality code. Writes in the 0x6000 to 0x7FFF window produce a work-RAM write enable and a 13-bit offset.

Top module: `mcart_unlock`

## Requirements
- R1: While reset is held, and after it is released with no write, the program windows read pages 0x00, 0x01, 0x06, 0x07 (windows 0 to 3). The pattern page is 0, the mirroring output is 0, the personality code is 0 and the armed flag is clear.
- R2: In the boot state (personality 0), a write of 0x20 to 0x8387 arms the cart and sets the windows to 0x04, 0x05, 0x06, 0x07 from the clock edge that takes the write. Any other value written to 0x8387 in that state changes no output.
- R3: A write of 0x21 to 0x4120 while armed, in personality 0, sets the personality code to 1 and the windows to 0x1C, 0x1D, 0x1E, 0x1F.
- R4: A write of 0x62 to 0x4120 while armed, in personality 0, sets the personality code to 2, the windows to 0x0C, 0x0D, 0x0E, 0x0F and the pattern page to 0.
- R5: A write to 0x4120 while not armed, of any value, changes no output. A value other than 0x21 or 0x62 written there while armed also changes no output.
- R6: In the same cycle as the write strobe, wram_we is 1 exactly when the address lies in 0x6000 to 0x7FFF. wram_off always equals address bits 12:0.
- R7: In personality 2, a write at 0x8000 or above updates the outputs as follows. Window 0 becomes 2*D[6:4] and window 1 becomes 2*D[6:4]+1. The pattern page becomes D[3:0] and mirror_h becomes D[7] (1 = horizontal, 0 = vertical). Windows 2 and 3 stay unchanged.
- R8: Once the personality code is non-zero it holds until reset. Later writes to 0x4120, or of 0x20 to 0x8387, do not select, arm or remap. In personality 2 such a write acts only through R7.
- R9: In personality 1, no write changes the program windows, the pattern page or mirror_h.
- R10: The personality code is 2 bits: 0 = boot menu, 1 = first game, 2 = second game. The value 3 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| prg_win0 | output | 8 | 8K program page for window 0 (0x8000) |
| prg_win1 | output | 8 | 8K program page for window 1 (0xA000) |
| prg_win2 | output | 8 | 8K program page for window 2 (0xC000) |
| prg_win3 | output | 8 | 8K program page for window 3 (0xE000) |
| chr_page | output | 8 | 8K pattern page |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| persona | output | 2 | Personality code |
| wram_we | output | 1 | Work-RAM write enable |
| wram_off | output | 13 | Work-RAM byte offset |

## Verification
The assertions assume that cpu_wr marks exactly one write per asserted cycle, with address and data stable across the rising edge that samples it. They also assume that reset is synchronous and held for at least one edge. The bench drives every write on the falling edge and drops the strobe one full cycle later. A fixed-seed random mix weights the arm and select addresses and the three key values heavily, so that arming, selection, stray writes and latch writes interleave within each reset epoch.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

  typedef enum logic [1:0] {
    PERS_NONE = 2'd0,
    PERS_ONE  = 2'd1,
    PERS_TWO  = 2'd2
  } persona_e;

  // Page shown in window idx right after reset
  function automatic logic [7:0] boot_page(input int idx);
    return (idx < 2) ? 8'(idx) : 8'(idx + 4);
  endfunction

  // Page shown in window idx once armed
  function automatic logic [7:0] armed_page(input int idx);
    return 8'(8'h04 + idx);
  endfunction

  // Pages committed by each game selection
  function automatic logic [7:0] p1_page(input int idx);
    return 8'(8'h1C + idx);
  endfunction

  function automatic logic [7:0] p2_page(input int idx);
    return 8'(8'h0C + idx);
  endfunction

  // 8K page number of one half of a 16K bank
  function automatic logic [7:0] half_of_16k(input logic [2:0] bank, input logic upper);
    return {4'b0000, bank, upper};
  endfunction

endpackage

// File: rtl/unlock_fsm.sv
module unlock_fsm
  import mcu_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] ARM_ADDR  = 16'h8387,
  parameter logic [7:0]  ARM_KEY   = 8'h20,
  parameter logic [15:0] SEL_ADDR  = 16'h4120,
  parameter logic [7:0]  SEL1_KEY  = 8'h21,
  parameter logic [7:0]  SEL2_KEY  = 8'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  output logic              arm_hit,
  output logic              sel1_hit,
  output logic              sel2_hit,
  output logic              latch_hit,
  output logic              armed,
  output logic [1:0]        persona
);

  persona_e pers_q;
  logic     armed_q;
  logic     boot_mode;
  logic     sel_wr;

  assign boot_mode = (pers_q == PERS_NONE);
  assign sel_wr    = cpu_wr && (cpu_addr == ADDR_W'(SEL_ADDR));

  assign arm_hit   = cpu_wr && boot_mode &&
                     (cpu_addr == ADDR_W'(ARM_ADDR)) && (cpu_data == DATA_W'(ARM_KEY));
  assign sel1_hit  = sel_wr && boot_mode && armed_q && (cpu_data == DATA_W'(SEL1_KEY));
  assign sel2_hit  = sel_wr && boot_mode && armed_q && (cpu_data == DATA_W'(SEL2_KEY));
  assign latch_hit = cpu_wr && (pers_q == PERS_TWO) && cpu_addr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pers_q  <= PERS_NONE;
    end else begin
      if (arm_hit)  armed_q <= 1'b1;
      if (sel1_hit) pers_q  <= PERS_ONE;
      else if (sel2_hit) pers_q <= PERS_TWO;
    end
  end

  assign armed   = armed_q;
  assign persona = pers_q;

  // R2: the arm write leaves the cart armed
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> armed);

  // R5: select writes while unarmed leave the personality alone
  a_r5_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !armed) |=> $stable(persona));

  // R8: a chosen personality is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (persona != 2'd0) |=> $stable(persona));

  // R10: code 3 is never produced
  a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    persona != 2'd3);

endmodule

// File: rtl/bank_map.sv
module bank_map
  import mcu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int N_WIN  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           cpu_data,
  input  logic                        arm_hit,
  input  logic                        sel1_hit,
  input  logic                        sel2_hit,
  input  logic                        latch_hit,
  input  logic [1:0]                  persona,
  output logic [N_WIN-1:0][PAGE_W-1:0] win,
  output logic [PAGE_W-1:0]           chr_page,
  output logic                        mirror_h
);

  localparam int LATCH_WINS = 2;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    logic [PAGE_W-1:0] page_q;
    if (i < LATCH_WINS) begin : g_latched
      always_ff @(posedge clk) begin
        if (!rst_n)         page_q <= PAGE_W'(boot_page(i));
        else if (sel1_hit)  page_q <= PAGE_W'(p1_page(i));
        else if (sel2_hit)  page_q <= PAGE_W'(p2_page(i));
        else if (arm_hit)   page_q <= PAGE_W'(armed_page(i));
        else if (latch_hit) page_q <= PAGE_W'(half_of_16k(cpu_data[6:4], 1'(i)));
      end
    end else begin : g_fixed
      always_ff @(posedge clk) begin
        if (!rst_n)        page_q <= PAGE_W'(boot_page(i));
        else if (sel1_hit) page_q <= PAGE_W'(p1_page(i));
        else if (sel2_hit) page_q <= PAGE_W'(p2_page(i));
        else if (arm_hit)  page_q <= PAGE_W'(armed_page(i));
      end
    end
    assign win[i] = page_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_page <= '0;
      mirror_h <= 1'b0;
    end else if (sel2_hit) begin
      chr_page <= '0;
    end else if (latch_hit) begin
      chr_page <= PAGE_W'(cpu_data[3:0]);
      mirror_h <= cpu_data[7];
    end
  end

  // R7: pattern page and mirroring follow the latched byte
  a_r7_chr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    latch_hit |=> (chr_page == PAGE_W'($past(cpu_data[3:0])) && mirror_h == $past(cpu_data[7])));

  // R7: upper windows are untouched by latch writes
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    latch_hit |=> $stable(win[N_WIN-1]));

  // R9: personality 1 freezes every page output
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (persona == 2'd1) |=> ($stable(win) && $stable(chr_page) && $stable(mirror_h)));

endmodule

// File: rtl/wram_decode.sv
module wram_decode #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic              wram_we,
  output logic [OFF_W-1:0]  wram_off
);

  localparam int          TOP_W   = ADDR_W - OFF_W;
  localparam logic [TOP_W-1:0] WRAM_SLOT = TOP_W'(3);

  assign wram_we  = cpu_wr && (cpu_addr[ADDR_W-1:OFF_W] == WRAM_SLOT);
  assign wram_off = cpu_addr[OFF_W-1:0];

  // R6: the enable never fires for the cartridge program space
  a_r6_not_prg: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_wr && !cpu_addr[ADDR_W-1]));

endmodule

// File: rtl/mcart_unlock.sv
module mcart_unlock
  import mcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  output logic [PAGE_W-1:0] prg_win0,
  output logic [PAGE_W-1:0] prg_win1,
  output logic [PAGE_W-1:0] prg_win2,
  output logic [PAGE_W-1:0] prg_win3,
  output logic [PAGE_W-1:0] chr_page,
  output logic              mirror_h,
  output logic [1:0]        persona,
  output logic              wram_we,
  output logic [OFF_W-1:0]  wram_off
);

  localparam int N_WIN = 4;

  logic arm_hit, sel1_hit, sel2_hit, latch_hit, armed;
  logic [N_WIN-1:0][PAGE_W-1:0] win;

  unlock_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_wr    (cpu_wr),
    .arm_hit   (arm_hit),
    .sel1_hit  (sel1_hit),
    .sel2_hit  (sel2_hit),
    .latch_hit (latch_hit),
    .armed     (armed),
    .persona   (persona)
  );

  bank_map #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .N_WIN(N_WIN)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_data  (cpu_data),
    .arm_hit   (arm_hit),
    .sel1_hit  (sel1_hit),
    .sel2_hit  (sel2_hit),
    .latch_hit (latch_hit),
    .persona   (persona),
    .win       (win),
    .chr_page  (chr_page),
    .mirror_h  (mirror_h)
  );

  wram_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_wram (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .wram_we  (wram_we),
    .wram_off (wram_off)
  );

  assign prg_win0 = win[0];
  assign prg_win1 = win[1];
  assign prg_win2 = win[2];
  assign prg_win3 = win[3];

  // R3/R4: a selection can only happen from an armed boot state
  a_r3_sel_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_hit || sel2_hit) |-> (armed && persona == 2'd0));

  // R1: reset restores the boot map
  a_r1_boot_map: assert property (@(posedge clk)
    !rst_n |=> (persona == 2'd0 && prg_win0 == 8'h00 && prg_win3 == 8'h07));

endmodule

// File: tb/sim_mcart_unlock.sv
`timescale 1ns/1ps
module sim_mcart_unlock;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic [7:0]  prg_win0, prg_win1, prg_win2, prg_win3, chr_page;
  logic        mirror_h, wram_we;
  logic [1:0]  persona;
  logic [12:0] wram_off;

  always #10 clk = ~clk;

  mcart_unlock u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .prg_win0(prg_win0), .prg_win1(prg_win1), .prg_win2(prg_win2), .prg_win3(prg_win3),
    .chr_page(chr_page), .mirror_h(mirror_h), .persona(persona),
    .wram_we(wram_we), .wram_off(wram_off)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [7:0] m_win [4];
  logic [7:0] m_chr;
  logic       m_mir;
  logic [1:0] m_pers;
  logic       m_armed;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit in_wram(input logic [15:0] a);
    return (a >= 16'h6000) && (a <= 16'h7FFF);
  endfunction

  task automatic model_reset();
    m_win[0] = 8'h00; m_win[1] = 8'h01; m_win[2] = 8'h06; m_win[3] = 8'h07;
    m_chr = 8'h00; m_mir = 1'b0; m_pers = 2'd0; m_armed = 1'b0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [1:0] p0;
    p0 = m_pers;
    if (p0 == 2'd0 && a == 16'h8387 && d == 8'h20) begin
      m_armed = 1'b1;
      for (int i = 0; i < 4; i++) m_win[i] = 8'(4 + i);
    end
    if (p0 == 2'd0 && m_armed && a == 16'h4120) begin
      if (d == 8'h21) begin
        m_pers = 2'd1;
        for (int i = 0; i < 4; i++) m_win[i] = 8'(28 + i);
      end else if (d == 8'h62) begin
        m_pers = 2'd2;
        for (int i = 0; i < 4; i++) m_win[i] = 8'(12 + i);
        m_chr = 8'h00;
      end
    end
    if (p0 == 2'd2 && a >= 16'h8000) begin
      m_win[0] = 8'(2 * int'(d[6:4]));
      m_win[1] = 8'(2 * int'(d[6:4]) + 1);
      m_chr    = 8'(d & 8'h0F);
      m_mir    = d[7];
    end
  endtask

  task automatic compare(input string req);
    chk({req, " win0"}, prg_win0, m_win[0]);
    chk({req, " win1"}, prg_win1, m_win[1]);
    chk({req, " win2"}, prg_win2, m_win[2]);
    chk({req, " win3"}, prg_win3, m_win[3]);
    chk({req, " chr"},  chr_page, m_chr);
    chk({req, " mirror"}, mirror_h, m_mir);
    chk({req, " R10 persona"}, persona, m_pers);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    #1;
    chk("R6 wram_we", wram_we, in_wram(a));
    chk("R6 wram_off", wram_off, a & 16'h1FFF);
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
    compare(req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
    model_reset();
    do_reset();

    // R5: unarmed select attempts
    wr(16'h4120, 8'h21, "R5 unarmed sel1");
    wr(16'h4120, 8'h62, "R5 unarmed sel2");
    // R2: wrong key at arm address
    wr(16'h8387, 8'h21, "R2 wrong key");
    wr(16'h8386, 8'h20, "R2 wrong addr");
    // R6 boundaries
    wr(16'h5FFF, 8'h11, "R6 below");
    wr(16'h6000, 8'h22, "R6 low edge");
    wr(16'h7FFF, 8'h33, "R6 high edge");
    // R2: arm
    wr(16'h8387, 8'h20, "R2 arm");
    wr(16'h4120, 8'h55, "R5 armed bad value");
    // R4: choose personality 2
    wr(16'h4120, 8'h62, "R4 select 2");
    // R7 latch patterns
    wr(16'h8000, 8'hFF, "R7 latch ff");
    wr(16'hFFFF, 8'h00, "R7 latch 00");
    wr(16'hC123, 8'hA5, "R7 latch a5");
    wr(16'h7FFF, 8'h77, "R7 below 8000 ignored");
    // R8: sticky
    wr(16'h4120, 8'h21, "R8 reselect ignored");
    wr(16'h8387, 8'h20, "R8 arm in p2 acts as latch");

    // R3 / R9
    do_reset();
    wr(16'h8387, 8'h20, "R2 arm again");
    wr(16'h4120, 8'h21, "R3 select 1");
    wr(16'h8000, 8'hFF, "R9 p1 frozen");
    wr(16'hA000, 8'h5A, "R9 p1 frozen b");
    wr(16'h4120, 8'h62, "R8 p1 sticky");

    // constrained random epochs
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      for (int k = 0; k < 60; k++) begin
        logic [15:0] a;
        logic [7:0]  d;
        case ($urandom % 6)
          0, 1: a = 16'h8387;
          2:    a = 16'h4120;
          3:    a = 16'h6000 | 16'($urandom % 8192);
          4:    a = 16'h8000 | 16'($urandom % 32768);
          default: a = 16'($urandom);
        endcase
        case ($urandom % 5)
          0: d = 8'h20;
          1: d = 8'h21;
          2: d = 8'h62;
          default: d = 8'($urandom);
        endcase
        wr(a, d, "R7 R8 random");
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule